// File: doc/BRIEF.md
# Multi-Channel Register Page Selector

This block sits behind an already-decoded serial-management slave. That slave provides address, write data, a write strobe and a read strobe. The block steers each access either to one shared register bank or to one of several per-channel banks. A single page register at address 0xff makes the choice. A write to the page register can pick the shared bank, one channel, or a broadcast mode. In broadcast mode, one write lands in every channel bank at once.

The block also keeps the interrupt state itself. Each channel has two sticky cause bits, one for loss of clock-recovery lock and one for loss of input signal, plus a per-cause enable. These are served at fixed channel addresses. A shared summary register shows which channels have an enabled pending cause. A single interrupt output is raised while any such cause is pending. The banks answer their read strobe in the same cycle. Read data from the block appears registered one cycle later.

Top module: `pgsel_top`

## Requirements
- R1: An access to address 0xff reads or writes the page register whatever the current page. It never raises a strobe toward any bank. A read there returns the page value.
- R2: When page bit 2 is 0, accesses to any address other than 0xff and 0x05 go only to the shared bank. No channel strobe is raised.
- R3: When page bit 2 is 1 and bit 3 is 0, page bits 1:0 pick the single channel that receives the access.
- R4: When page bits 2 and 3 are both 1, a write strobes all channel banks together. A read strobes only channel 0 and returns channel 0's data.
- R5: The page register resets to 0x00. A write to it stores bits 3:0 and forces bits 7:4 to zero.
- R6: Channel address 0x01 is served by the block and reports the latched causes. Bit 4 is lost lock and bit 0 is lost signal. A cause stays set after its event input drops. A read returns the causes and then clears them. An event present in the clearing cycle stays latched. Writes to 0x01 have no effect.
- R7: Channel address 0x02 is served by the block and holds the cause enables. Bit 4 enables lost lock and bit 0 enables lost signal, and it resets to 0x11. A broadcast write updates every channel's enables. A disabled cause is still latched, but it raises no interrupt and no summary flag.
- R8: In shared mode, address 0x05 is served by the block. Bit n is set while channel n has an enabled latched cause, and bits 7:4 read 0. The shared bank sees no strobe for it.
- R9: irq_o is high exactly while some channel has an enabled latched cause. It rises in the cycle after the clock edge that samples the event.
- R10: rdata_o takes the read data at the clock edge ending a read-strobe cycle. It holds that value until the next read and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address from the slave |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one cycle per access |
| re_i | input | 1 | Read strobe, one cycle per access |
| rdata_o | output | 8 | Registered read data |
| sh_we_o | output | 1 | Shared bank write strobe |
| sh_re_o | output | 1 | Shared bank read strobe |
| sh_addr_o | output | 8 | Shared bank address |
| sh_wdata_o | output | 8 | Shared bank write data |
| sh_rdata_i | input | 8 | Shared bank read data, same cycle |
| ch_we_o | output | 4 | Per-channel write strobes |
| ch_re_o | output | 4 | Per-channel read strobes |
| ch_addr_o | output | 8 | Channel bank address |
| ch_wdata_o | output | 8 | Channel bank write data |
| ch_rdata_i | input | 32 | Channel read data, channel n at bits 8n+7:8n |
| lol_i | input | 4 | Per-channel loss-of-lock event |
| los_i | input | 4 | Per-channel loss-of-signal event |
| irq_o | output | 1 | Interrupt, any enabled latched cause |

## Verification
A clearing read of a channel's cause register can fall in the same cycle as a new event on that channel. The bench first latches a lost-lock cause. It then raises the lost-lock input again during the very read strobe that reads register 0x01. That read must return the old cause. A second read must show the cause still latched, because the new event wins over the clear. A plain read with no event must leave 0x00 behind.

// File: rtl/pgsel_pkg.sv
package pgsel_pkg;
  localparam logic [7:0] PAGE_ADDR = 8'hff;
  localparam logic [7:0] STAT_ADDR = 8'h01;
  localparam logic [7:0] MASK_ADDR = 8'h02;
  localparam logic [7:0] SUMM_ADDR = 8'h05;
  localparam int PG_CHAN = 2;
  localparam int PG_BCAST = 3;
  localparam int LOL_BIT = 4;
  localparam int LOS_BIT = 0;

  typedef enum logic [2:0] {
    RD_NONE, RD_PAGE, RD_SHARED, RD_SUMM, RD_CHAN, RD_STAT, RD_MASK
  } rd_src_e;
endpackage

// File: rtl/pgsel_decode.sv
module pgsel_decode
  import pgsel_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int CW = $clog2(N_CH)
) (
  input  logic [7:0]      page_i,
  input  logic [7:0]      addr_i,
  input  logic            we_i,
  input  logic            re_i,
  output logic            page_we_o,
  output logic            sh_we_o,
  output logic            sh_re_o,
  output logic [N_CH-1:0] ch_we_o,
  output logic [N_CH-1:0] ch_re_o,
  output logic [N_CH-1:0] stat_rd_o,
  output logic [N_CH-1:0] mask_we_o,
  output rd_src_e         rd_src_o,
  output logic [CW-1:0]   rd_ch_o
);
  logic            chan_mode, bcast;
  logic [CW-1:0]   sel;
  logic [N_CH-1:0] wr_tgt, rd_tgt;

  assign chan_mode = page_i[PG_CHAN];
  assign bcast     = page_i[PG_BCAST];
  assign sel       = page_i[CW-1:0];
  assign rd_ch_o   = bcast ? '0 : sel;
  assign wr_tgt    = bcast ? '1 : (N_CH'(1) << sel);
  assign rd_tgt    = N_CH'(1) << rd_ch_o;

  always_comb begin
    page_we_o = 1'b0;
    sh_we_o   = 1'b0;
    sh_re_o   = 1'b0;
    ch_we_o   = '0;
    ch_re_o   = '0;
    stat_rd_o = '0;
    mask_we_o = '0;
    rd_src_o  = RD_NONE;
    if (addr_i == PAGE_ADDR) begin
      page_we_o = we_i;
      if (re_i) rd_src_o = RD_PAGE;
    end else if (!chan_mode) begin
      if (addr_i == SUMM_ADDR) begin
        if (re_i) rd_src_o = RD_SUMM;
      end else begin
        sh_we_o = we_i;
        sh_re_o = re_i;
        if (re_i) rd_src_o = RD_SHARED;
      end
    end else if (addr_i == STAT_ADDR) begin
      stat_rd_o = re_i ? rd_tgt : '0;
      if (re_i) rd_src_o = RD_STAT;
    end else if (addr_i == MASK_ADDR) begin
      mask_we_o = we_i ? wr_tgt : '0;
      if (re_i) rd_src_o = RD_MASK;
    end else begin
      ch_we_o = we_i ? wr_tgt : '0;
      ch_re_o = re_i ? rd_tgt : '0;
      if (re_i) rd_src_o = RD_CHAN;
    end
  end
endmodule

// File: rtl/pgsel_cause.sv
module pgsel_cause
  import pgsel_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lol_i,
  input  logic          los_i,
  input  logic          clr_i,
  input  logic          mask_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] mask_o,
  output logic          pend_o
);
  logic lol_q, los_q, en_lol_q, en_los_q;

  // new event beats a clearing read in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lol_q <= 1'b0;
      los_q <= 1'b0;
    end else begin
      lol_q <= lol_i | (lol_q & ~clr_i);
      los_q <= los_i | (los_q & ~clr_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_lol_q <= 1'b1;
      en_los_q <= 1'b1;
    end else if (mask_we_i) begin
      en_lol_q <= wdata_i[LOL_BIT];
      en_los_q <= wdata_i[LOS_BIT];
    end
  end

  always_comb begin
    status_o = '0;
    status_o[LOL_BIT] = lol_q;
    status_o[LOS_BIT] = los_q;
    mask_o = '0;
    mask_o[LOL_BIT] = en_lol_q;
    mask_o[LOS_BIT] = en_los_q;
  end

  assign pend_o = (lol_q & en_lol_q) | (los_q & en_los_q);

  a_r6_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lol_i |=> status_o[LOL_BIT]);
  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !los_i) |=> !status_o[LOS_BIT]);
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[LOL_BIT] && !clr_i) |=> status_o[LOL_BIT]);
  a_r7_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> mask_o[LOL_BIT] == $past(wdata_i[LOL_BIT]));
endmodule

// File: rtl/pgsel_top.sv
module pgsel_top
  import pgsel_pkg::*;
#(
  parameter int N_CH = 4,
  parameter int DW = 8,
  localparam int CW = $clog2(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             we_i,
  input  logic             re_i,
  output logic [DW-1:0]    rdata_o,
  output logic             sh_we_o,
  output logic             sh_re_o,
  output logic [7:0]       sh_addr_o,
  output logic [DW-1:0]    sh_wdata_o,
  input  logic [DW-1:0]    sh_rdata_i,
  output logic [N_CH-1:0]  ch_we_o,
  output logic [N_CH-1:0]  ch_re_o,
  output logic [7:0]       ch_addr_o,
  output logic [DW-1:0]    ch_wdata_o,
  input  logic [N_CH*DW-1:0] ch_rdata_i,
  input  logic [N_CH-1:0]  lol_i,
  input  logic [N_CH-1:0]  los_i,
  output logic             irq_o
);
  localparam logic [DW-1:0] PAGE_KEEP = DW'(8'h0f);

  logic [7:0]             page_q;
  logic                   page_we;
  logic [N_CH-1:0]        stat_rd, mask_we, pend;
  logic [N_CH-1:0][DW-1:0] status, mask;
  rd_src_e                rd_src;
  logic [CW-1:0]          rd_ch;
  logic [DW-1:0]          rd_next, rdata_q;

  pgsel_decode #(.N_CH(N_CH)) u_decode (
    .page_i    (page_q),
    .addr_i    (addr_i),
    .we_i      (we_i),
    .re_i      (re_i),
    .page_we_o (page_we),
    .sh_we_o   (sh_we_o),
    .sh_re_o   (sh_re_o),
    .ch_we_o   (ch_we_o),
    .ch_re_o   (ch_re_o),
    .stat_rd_o (stat_rd),
    .mask_we_o (mask_we),
    .rd_src_o  (rd_src),
    .rd_ch_o   (rd_ch)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pgsel_cause #(.DW(DW)) u_cause (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lol_i     (lol_i[c]),
      .los_i     (los_i[c]),
      .clr_i     (stat_rd[c]),
      .mask_we_i (mask_we[c]),
      .wdata_i   (wdata_i),
      .status_o  (status[c]),
      .mask_o    (mask[c]),
      .pend_o    (pend[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) page_q <= '0;
    else if (page_we) page_q <= 8'(wdata_i & PAGE_KEEP);
  end

  always_comb begin
    rd_next = rdata_q;
    unique case (rd_src)
      RD_PAGE:   rd_next = DW'(page_q);
      RD_SHARED: rd_next = sh_rdata_i;
      RD_SUMM:   rd_next = DW'(pend);
      RD_CHAN:   rd_next = ch_rdata_i[int'(rd_ch)*DW +: DW];
      RD_STAT:   rd_next = status[rd_ch];
      RD_MASK:   rd_next = mask[rd_ch];
      default:   rd_next = rdata_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else rdata_q <= rd_next;
  end

  assign rdata_o    = rdata_q;
  assign sh_addr_o  = addr_i;
  assign sh_wdata_o = wdata_i;
  assign ch_addr_o  = addr_i;
  assign ch_wdata_o = wdata_i;
  assign irq_o      = |pend;

  a_r1_page_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == PAGE_ADDR) |-> (!sh_we_o && !sh_re_o && ch_we_o == '0 && ch_re_o == '0));
  a_r2_shared_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !page_q[PG_CHAN] |-> (ch_we_o == '0 && ch_re_o == '0));
  a_r3_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_q[PG_CHAN] && !page_q[PG_BCAST]) |-> $onehot0(ch_we_o));
  a_r4_bcast_read_ch0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_q[PG_CHAN] && page_q[PG_BCAST]) |-> (ch_re_o[N_CH-1:1] == '0));
  a_r5_page_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == PAGE_ADDR) |=> (page_q == 8'($past(wdata_i) & PAGE_KEEP)));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: tb/pgsel_top_bench.sv
module pgsel_top_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0, wdata_i = '0;
  logic        we_i = 1'b0, re_i = 1'b0;
  logic [7:0]  rdata_o;
  logic        sh_we_o, sh_re_o;
  logic [7:0]  sh_addr_o, sh_wdata_o, sh_rdata_i;
  logic [3:0]  ch_we_o, ch_re_o;
  logic [7:0]  ch_addr_o, ch_wdata_o;
  logic [31:0] ch_rdata_i;
  logic [3:0]  lol_i = '0, los_i = '0;
  logic        irq_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] sh_mem [256];
  logic [7:0] ch_mem [4][256];

  always #5 clk_i = ~clk_i;

  pgsel_top u_pgsel_top (.*);

  assign sh_rdata_i = sh_mem[sh_addr_o];
  always_comb
    for (int c = 0; c < 4; c++) ch_rdata_i[c*8 +: 8] = ch_mem[c][ch_addr_o];

  always_ff @(posedge clk_i) begin
    if (sh_we_o) sh_mem[sh_addr_o] <= sh_wdata_o;
    for (int c = 0; c < 4; c++) if (ch_we_o[c]) ch_mem[c][ch_addr_o] <= ch_wdata_o;
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i); we_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i); addr_i = a; re_i = 1'b1;
    @(negedge clk_i); re_i = 1'b0; d = rdata_o;
  endtask

  task automatic pulse_lol(int c);
    @(negedge clk_i); lol_i[c] = 1'b1;
    @(negedge clk_i); lol_i[c] = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R10 rdata reset", rdata_o, 8'h00);
    check("R9 irq reset", {7'b0, irq_o}, 8'h00);
    rd(8'hff, d);
    check("R5 page reset", d, 8'h00);
  endtask

  task automatic t_shared;
    logic [7:0] d;
    @(negedge clk_i); addr_i = 8'h10; wdata_i = 8'ha5; we_i = 1'b1;
    #1 check("R2 no channel strobe", {4'b0, ch_we_o}, 8'h00);
    @(negedge clk_i); we_i = 1'b0;
    rd(8'h10, d);
    check("R2 shared readback", d, 8'ha5);
    check("R2 channel untouched", ch_mem[0][8'h10], 8'h00);
  endtask

  task automatic t_page;
    logic [7:0] d;
    @(negedge clk_i); addr_i = 8'hff; wdata_i = 8'hf4; we_i = 1'b1;
    #1 check("R1 no bank strobe", {2'b0, sh_we_o, sh_re_o, ch_we_o}, 8'h00);
    @(negedge clk_i); we_i = 1'b0;
    rd(8'hff, d);
    check("R5 upper nibble zero", d, 8'h04);
    wr(8'h10, 8'h11);
    wr(8'hff, 8'h06);
    wr(8'h10, 8'h22);
    rd(8'h10, d);
    check("R3 channel 2 readback", d, 8'h22);
    check("R3 channel 0 kept", ch_mem[0][8'h10], 8'h11);
    check("R3 channel 1 untouched", ch_mem[1][8'h10], 8'h00);
    wr(8'hff, 8'h00);
    rd(8'h10, d);
    check("R1 page write from channel page", d, 8'ha5);
  endtask

  task automatic t_bcast;
    logic [7:0] d;
    wr(8'hff, 8'h0c);
    wr(8'h20, 8'h5a);
    for (int c = 0; c < 4; c++) check("R4 broadcast write", ch_mem[c][8'h20], 8'h5a);
    wr(8'hff, 8'h04); wr(8'h30, 8'h01);
    wr(8'hff, 8'h05); wr(8'h30, 8'h02);
    wr(8'hff, 8'h0c);
    rd(8'h30, d);
    check("R4 broadcast read ch0", d, 8'h01);
  endtask

  task automatic t_events;
    logic [7:0] d;
    pulse_lol(1);
    check("R9 irq raised", {7'b0, irq_o}, 8'h01);
    wr(8'hff, 8'h00);
    rd(8'h05, d);
    check("R8 summary ch1", d, 8'h02);
    check("R8 shared bank not read", sh_mem[8'h05], 8'h00);
    wr(8'hff, 8'h05);
    rd(8'h01, d);
    check("R6 lost lock latched", d, 8'h10);
    rd(8'h01, d);
    check("R6 cleared by read", d, 8'h00);
    check("R9 irq cleared", {7'b0, irq_o}, 8'h00);
    @(negedge clk_i); los_i[3] = 1'b1;
    @(negedge clk_i); los_i[3] = 1'b0;
    wr(8'hff, 8'h07);
    rd(8'h01, d);
    check("R6 lost signal latched", d, 8'h01);
  endtask

  task automatic t_mask;
    logic [7:0] d;
    wr(8'hff, 8'h06);
    wr(8'h02, 8'h01);
    pulse_lol(2);
    check("R7 masked no irq", {7'b0, irq_o}, 8'h00);
    rd(8'h01, d);
    check("R7 masked cause still latched", d, 8'h10);
    wr(8'hff, 8'h0c);
    wr(8'h02, 8'h11);
    wr(8'hff, 8'h07);
    rd(8'h02, d);
    check("R7 broadcast enables", d, 8'h11);
    rd(8'h02, d);
    wr(8'hff, 8'h06);
    rd(8'h02, d);
    check("R7 ch2 enables restored", d, 8'h11);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    wr(8'hff, 8'h04);
    pulse_lol(0);
    @(negedge clk_i); addr_i = 8'h01; re_i = 1'b1; lol_i[0] = 1'b1;
    @(negedge clk_i); re_i = 1'b0; lol_i[0] = 1'b0; d = rdata_o;
    check("R6 collide read old", d, 8'h10);
    rd(8'h01, d);
    check("R6 collide event kept", d, 8'h10);
    rd(8'h01, d);
    check("R6 cleared after collide", d, 8'h00);
    wr(8'h01, 8'hff);
    rd(8'h01, d);
    check("R6 write ignored", d, 8'h00);
    check("R6 bank not written", ch_mem[0][8'h01], 8'h00);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin
      sh_mem[a] = '0;
      for (int c = 0; c < 4; c++) ch_mem[c][a] = '0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_shared();
    t_page();
    t_bcast();
    t_events();
    t_mask();
    t_collide();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule